// File: doc/BRIEF.md
# Flash Write Control Register

This block is a byte-wide special-function control register for a small 8-bit microcontroller. It decides where external data-move writes land and arms flash erase operations. While its program-write enable is set, the mode output `flash_wr_mode` tells the memory path to send a data-move write through the data pointer into program flash at the pointer address. While it is clear, such writes go to data RAM. The enable clears itself when the flash controller reports that one byte has been programmed. Software cannot change it while interrupts are globally enabled.

Three more fields sit in the same register. The mass-erase arm must be set again before every erase. When the erase trigger arrives while the arm is set, the block issues a one-cycle start pulse, and that pulse disarms the arm. The security latch can be set by software but is cleared only by reset. While it is set, it drives an output that blocks external reads of flash and of the coprocessor program RAM. The preboot status bit is read-only and reflects an input pin.

All register access is plain strobe-and-data control, with no valid/ready handshake. A write strobe is taken in the cycle it is high. There is no back-pressure: the register accepts every access, and a read returns data in the same cycle.

Top module: `fwc_reg`

## Requirements
- R1: After reset, the program-write enable, the mass-erase arm and the security latch are all 0, and so are `flash_wr_mode`, `secure_lock` and `erase_start`.
- R2: A register write with `irq_en`=0 loads data bit 0 into the program-write enable from the next cycle on. `flash_wr_mode` equals the program-write enable.
- R3: A register write with `irq_en`=1 leaves the program-write enable unchanged.
- R4: A `byte_done` pulse clears the program-write enable in the next cycle. It takes precedence over a register write in the same cycle.
- R5: A register write loads data bit 1 into the mass-erase arm, whatever the value of `irq_en`.
- R6: When `erase_trig` is high while the arm is 1, `erase_start` is high in that same cycle. The arm reads 0 from the next cycle on, so a trigger held high gives exactly one pulse. With the arm at 0, a trigger gives no pulse.
- R7: Writing 1 in data bit 6 sets the security latch. Writing 0 in bit 6 has no effect. Only reset clears the latch. `secure_lock` equals the latch.
- R8: While `reg_rd` is high, `reg_rdata` holds: bit 7 = `preboot_in` (live), bit 6 = security latch, bits 5..2 = 0, bit 1 = mass-erase arm, bit 0 = program-write enable. While `reg_rd` is low, `reg_rdata` is 0.
- R9: Register writes never change read bits 7 or 5..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data |
| irq_en | input | 1 | Interrupts globally enabled |
| byte_done | input | 1 | One flash byte finished programming |
| erase_trig | input | 1 | Software erase trigger |
| preboot_in | input | 1 | Preboot sequence active |
| flash_wr_mode | output | 1 | Data-move writes go to program flash |
| erase_start | output | 1 | One-cycle mass-erase start |
| secure_lock | output | 1 | Blocks external flash and program RAM reads |

## Verification
The bench builds the block with its default 8-bit data width. At this width, all 256 write values can be swept twice, once with interrupts disabled and once with interrupts enabled. After every write, the bench reads back the register and compares it to an arithmetic model of each field. This sweep reaches the interrupt lock, the write-once latch and the reserved bits exhaustively. Directed sequences then cover the byte-done precedence, erase triggers with the arm set and clear, a held trigger, and the clearing of the latch by reset.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int PWE_BIT = 0;
  localparam int MEE_BIT = 1;
  localparam int SEC_BIT = 6;
  localparam int PRE_BIT = 7;
endpackage

// File: rtl/fwc_pwe.sv
module fwc_pwe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic irq_en,
  input  logic byte_done,
  output logic pwe_q
);
  logic load;
  assign load = wr_en && !irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pwe_q <= 1'b0;
    else if (byte_done) pwe_q <= 1'b0;
    else if (load)      pwe_q <= wr_bit;
  end

  // R3
  pwe_irq_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && irq_en && !byte_done) |=> $stable(pwe_q));
  // R4
  pwe_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !pwe_q);
endmodule

// File: rtl/fwc_erase.sv
module fwc_erase (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic trig,
  output logic arm_q,
  output logic start
);
  assign start = trig && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (start)  arm_q <= 1'b0;
    else if (wr_en)  arm_q <= wr_bit;
  end

  // R6
  erase_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !arm_q);
  // R6
  erase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/fwc_secure.sv
module fwc_secure (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic sec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sec_q <= 1'b0;
    else if (wr_en && wr_bit)  sec_q <= 1'b1;
  end

  // R7
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |=> sec_q);
endmodule

// File: rtl/fwc_reg.sv
module fwc_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_en,
  input  logic          byte_done,
  input  logic          erase_trig,
  input  logic          preboot_in,
  output logic          flash_wr_mode,
  output logic          erase_start,
  output logic          secure_lock
);
  import fwc_pkg::*;

  logic pwe, arm, sec;
  logic [DW-1:0] view;
  logic unused_wbits;

  fwc_pwe u_pwe (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[PWE_BIT]),
    .irq_en(irq_en), .byte_done(byte_done), .pwe_q(pwe)
  );

  fwc_erase u_erase (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[MEE_BIT]),
    .trig(erase_trig), .arm_q(arm), .start(erase_start)
  );

  fwc_secure u_sec (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_bit(reg_wdata[SEC_BIT]),
    .sec_q(sec)
  );

  for (genvar i = 0; i < DW; i++) begin : g_view
    if (i == PWE_BIT)      begin : g_p assign view[i] = pwe;        end
    else if (i == MEE_BIT) begin : g_m assign view[i] = arm;        end
    else if (i == SEC_BIT) begin : g_s assign view[i] = sec;        end
    else if (i == PRE_BIT) begin : g_b assign view[i] = preboot_in; end
    else                   begin : g_r assign view[i] = 1'b0;       end
  end

  assign unused_wbits  = ^{reg_wdata[PRE_BIT], reg_wdata[SEC_BIT-1:MEE_BIT+1]};
  assign reg_rdata     = reg_rd ? view : '0;
  assign flash_wr_mode = pwe;
  assign secure_lock   = sec;

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !irq_en && !byte_done) |=> (flash_wr_mode == $past(reg_wdata[PWE_BIT])));
endmodule

// File: tb/sim_fwc_reg.sv
module sim_fwc_reg;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_en = 0, byte_done = 0, erase_trig = 0, preboot_in = 0;
  logic flash_wr_mode, erase_start, secure_lock;
  int errs = 0, checks = 0;
  logic m_pwe, m_arm, m_sec;

  always #4 clk = ~clk;

  fwc_reg u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_check(string req);
    reg_rd = 1; #1;
    chk(req, reg_rdata, {preboot_in, m_sec, 4'b0, m_arm, m_pwe});
    chk(req, {flash_wr_mode, secure_lock}, {m_pwe, m_sec});
    reg_rd = 0; #1;
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    m_pwe = 0; m_arm = 0; m_sec = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_check("R1");
    chk("R1", erase_start, 0);
    // R8 idle read is zero
    chk("R8", reg_rdata, 0);
    // R2 R3 R5 R7 R9 exhaustive sweep
    for (int ie = 0; ie < 2; ie++) begin
      for (int v = 0; v < 256; v++) begin
        irq_en = ie[0];
        preboot_in = v[3];
        wr(v[7:0]);
        if (!ie[0]) m_pwe = v[0];
        m_arm = v[1];
        if (v[6]) m_sec = 1;
        rd_check(ie ? "R3" : "R2");
      end
    end
    irq_en = 0; preboot_in = 1;
    // R7 write 0 to security bit keeps it
    wr(8'h00); m_pwe = 0; m_arm = 0;
    rd_check("R7");
    // R4 byte_done clears pwe
    wr(8'h01); m_pwe = 1; rd_check("R2");
    @(negedge clk); byte_done = 1; @(negedge clk); byte_done = 0;
    m_pwe = 0; rd_check("R4");
    // R4 precedence over simultaneous write
    @(negedge clk); byte_done = 1; reg_wr = 1; reg_wdata = 8'h01;
    @(negedge clk); byte_done = 0; reg_wr = 0;
    rd_check("R4");
    // R6 trigger without arm
    @(negedge clk); erase_trig = 1; #1; chk("R6", erase_start, 0);
    @(negedge clk); erase_trig = 0;
    // R6 armed trigger held two cycles
    wr(8'h02); m_arm = 1;
    erase_trig = 1; #1; chk("R6", erase_start, 1);
    @(negedge clk); #1; chk("R6", erase_start, 0);
    m_arm = 0; rd_check("R6");
    erase_trig = 0;
    // R5 arm writable with interrupts enabled
    irq_en = 1; wr(8'h02); m_arm = 1; rd_check("R5");
    irq_en = 0;
    // R7 reset clears latch
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_pwe = 0; m_arm = 0; m_sec = 0; preboot_in = 0;
    rd_check("R7");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule